// File: doc/BRIEF.md
# Alarm and Interrupt Pin Controller

This block turns six internal health conditions of a clock-conditioning circuit into three status pins and a small set of host-visible registers. The conditions are loss of signal on input 1, input 2 and the reference, frequency offset on inputs 1 and 2, and loss of lock of the loop. For every condition the block keeps a live status bit, a sticky flag and a mask bit. The unmasked flags are ORed into one combined interrupt.

The first pin carries either that interrupt or an input-1 alarm. The second pin carries an input-2 alarm. The third pin carries the lock state. Each pin has its own enable and active-level control and stays tristated while disabled. The host writes configuration, masks and flag clears through a simple register-write port.

The detectors and the host serial bus sit outside the block. Pin data and pin output-enable are separate outputs, so a pad ring can build the tristate driver.

Top module: `alarm_pin_ctrl`

## Requirements
- R1: After synchronous reset all three pin output-enables are 0 and all pin data outputs are 0. Flags and status are 0, all six mask bits are 1, and the configuration register is 0.
- R2: Condition bit order on `cond_i`, `status_o`, `flags_o` and the mask is: 0 input-1 loss of signal, 1 input-2 loss of signal, 2 reference loss of signal, 3 input-1 frequency offset, 4 input-2 frequency offset, 5 loss of lock. A flag sets on the clock edge where its condition is 1 and was 0 at the previous edge. It stays set after the condition falls.
- R3: A write to address 2 clears every flag whose data bit is 0 and leaves flags whose data bit is 1. If a rising condition arrives on the same edge as its clear, the flag stays set.
- R4: `irq_o` is 1 exactly when some flag is set whose mask bit (address 1, bits 5:0) is 0.
- R5: Configuration sits at address 0: bit0 interrupt enable, bit1 input-1 alarm enable, bit2 input-2 alarm enable, bit3 lock pin enable, bit4 interrupt polarity, bit5 alarm polarity, bit6 lock polarity, bit7 frequency-offset-in-alarm enable. A polarity bit of 1 means active high. With bit0 = 1, pin 1 is driven with the interrupt at the interrupt polarity, whatever the value of bit1.
- R6: With bit0 = 0 and bit1 = 1, pin 1 is driven with input-1 bad. This is live loss of signal on input 1, ORed with live frequency offset on input 1 when bit7 = 1. Its level follows the alarm polarity.
- R7: With bit0 = 0 and bit1 = 0, pin 1 is tristated: output-enable 0 and data 0.
- R8: With bit2 = 1, pin 2 is driven with input-2 bad, formed the same way from the input-2 conditions and at the alarm polarity. Otherwise pin 2 is tristated.
- R9: With bit3 = 1, the lock pin is driven with live loss of lock at the lock polarity. Otherwise it is tristated. `status_o[5]` always shows live loss of lock.
- R10: `status_o` equals `cond_i` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 6 | Live conditions from the detectors |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| status_o | output | 6 | Registered live status |
| flags_o | output | 6 | Sticky flags |
| mask_o | output | 6 | Mask bits |
| cfg_o | output | 8 | Configuration register |
| irq_o | output | 1 | Combined interrupt, active high |
| pin1_o | output | 1 | Pin 1 data |
| pin1_oe | output | 1 | Pin 1 output enable |
| pin2_o | output | 1 | Pin 2 data |
| pin2_oe | output | 1 | Pin 2 output enable |
| lolpin_o | output | 1 | Lock pin data |
| lolpin_oe | output | 1 | Lock pin output enable |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a new rising edge of the same condition. Reaching it needs the condition low for one cycle and then raised while the clear write is applied. A directed step builds this after the table, by dropping input-2 loss of signal and then raising it together with a clear of all bits.

The precedence on pin 1 is also covered. The table enables the interrupt and the input-1 alarm together, and the check expects interrupt behaviour.

// File: rtl/alarm_pin_pkg.sv
package alarm_pin_pkg;
    localparam int NUM_COND  = 6;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 8;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

    typedef enum int {
        C_LOS1 = 0, C_LOS2 = 1, C_LOSREF = 2, C_FOS1 = 3, C_FOS2 = 4, C_LOL = 5
    } cond_idx_e;

    typedef struct packed {
        logic fos_alarm_en;
        logic lol_pol;
        logic alarm_pol;
        logic int_pol;
        logic lol_en;
        logic ck2_en;
        logic ck1_en;
        logic int_en;
    } pin_cfg_t;

    typedef struct packed {
        logic d;
        logic oe;
    } pin_drv_t;

    function automatic pin_drv_t drive(input logic active, input logic pol);
        pin_drv_t p;
        p.oe = 1'b1;
        p.d  = pol ? active : ~active;
        return p;
    endfunction
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
    import alarm_pin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output pin_cfg_t          cfg_q,
    output logic [NUM_COND-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG)  cfg_q  <= pin_cfg_t'(wr_data);
            if (wr_addr == ADDR_MASK) mask_q <= wr_data[NUM_COND-1:0];
        end
    end

    // R1
    mask_reset_chk: assert property (@(posedge clk) rst |=> (mask_q == '1 && cfg_q == '0));
endmodule

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank
    import alarm_pin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                clr_en,
    input  logic [NUM_COND-1:0] clr_keep,
    input  logic [NUM_COND-1:0] mask_i,
    output logic [NUM_COND-1:0] status_q,
    output logic [NUM_COND-1:0] flags_q,
    output logic                irq
);
    logic [NUM_COND-1:0] rise;
    logic [NUM_COND-1:0] keep;

    assign rise = cond_i & ~status_q;
    assign keep = clr_en ? clr_keep : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            flags_q  <= '0;
        end else begin
            status_q <= cond_i;
            flags_q  <= (flags_q & keep) | rise;
        end
    end

    assign irq = |(flags_q & ~mask_i);

    for (genvar i = 0; i < NUM_COND; i++) begin : g_chk
        // R2
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            (cond_i[i] && !status_q[i]) |=> flags_q[i]);
        // R3
        flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !(clr_en && !clr_keep[i])) |=> flags_q[i]);
        // R10
        status_track_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> status_q[i] == $past(cond_i[i]));
    end
endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux
    import alarm_pin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  pin_cfg_t            cfg,
    input  logic [NUM_COND-1:0] status,
    input  logic                irq,
    output pin_drv_t            pin1,
    output pin_drv_t            pin2,
    output pin_drv_t            lolpin
);
    logic bad1, bad2;

    assign bad1 = status[C_LOS1] | (cfg.fos_alarm_en & status[C_FOS1]);
    assign bad2 = status[C_LOS2] | (cfg.fos_alarm_en & status[C_FOS2]);

    always_comb begin
        if (cfg.int_en)      pin1 = drive(irq, cfg.int_pol);
        else if (cfg.ck1_en) pin1 = drive(bad1, cfg.alarm_pol);
        else                 pin1 = '0;
    end

    assign pin2   = cfg.ck2_en ? drive(bad2, cfg.alarm_pol) : '0;
    assign lolpin = cfg.lol_en ? drive(status[C_LOL], cfg.lol_pol) : '0;

    // R5
    int_prec_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.int_en |-> (pin1.oe && (pin1.d == (irq ~^ cfg.int_pol))));
    // R7
    pin1_tri_chk: assert property (@(posedge clk) disable iff (rst)
        !pin1.oe |-> !pin1.d);
    // R9
    lol_tri_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.lol_en |-> (!lolpin.oe && !lolpin.d));
endmodule

// File: rtl/alarm_pin_ctrl.sv
module alarm_pin_ctrl
    import alarm_pin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_COND-1:0] status_o,
    output logic [NUM_COND-1:0] flags_o,
    output logic [NUM_COND-1:0] mask_o,
    output logic [DATA_W-1:0]   cfg_o,
    output logic                irq_o,
    output logic                pin1_o,
    output logic                pin1_oe,
    output logic                pin2_o,
    output logic                pin2_oe,
    output logic                lolpin_o,
    output logic                lolpin_oe
);
    pin_cfg_t cfg;
    pin_drv_t p1, p2, pl;
    logic     clr_en;

    assign clr_en = wr_en && (wr_addr == ADDR_FLAG);

    alarm_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_q(cfg), .mask_q(mask_o)
    );

    alarm_flag_bank u_flags (
        .clk(clk), .rst(rst), .cond_i(cond_i), .clr_en(clr_en),
        .clr_keep(wr_data[NUM_COND-1:0]), .mask_i(mask_o),
        .status_q(status_o), .flags_q(flags_o), .irq(irq_o)
    );

    alarm_pin_mux u_mux (
        .clk(clk), .rst(rst), .cfg(cfg), .status(status_o), .irq(irq_o),
        .pin1(p1), .pin2(p2), .lolpin(pl)
    );

    assign cfg_o     = cfg;
    assign pin1_o    = p1.d;
    assign pin1_oe   = p1.oe;
    assign pin2_o    = p2.d;
    assign pin2_oe   = p2.oe;
    assign lolpin_o  = pl.d;
    assign lolpin_oe = pl.oe;

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flags_o != '0));
    // R8
    pin2_tri_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.ck2_en |-> (!pin2_oe && !pin2_o));
endmodule

// File: tb/tb_alarm_pin_ctrl.sv
module tb_alarm_pin_ctrl;
    logic       clk = 0;
    logic       rst;
    logic [5:0] cond_i;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [5:0] status_o, flags_o, mask_o;
    logic [7:0] cfg_o;
    logic irq_o, pin1_o, pin1_oe, pin2_o, pin2_oe, lolpin_o, lolpin_oe;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [5:0] m_stat, m_flag, m_mask;
    logic [7:0] m_cfg;

    always #10 clk = ~clk;

    alarm_pin_ctrl dut (.*);

    // stimulus vectors: {cond[5:0], wr_en, addr[1:0], data[7:0]}
    localparam int NV = 15;
    localparam logic [16:0] VEC [NV] = '{
        {6'h00, 1'b1, 2'd1, 8'h00},
        {6'h00, 1'b1, 2'd0, 8'h11},
        {6'h01, 1'b0, 2'd0, 8'h00},
        {6'h00, 1'b1, 2'd2, 8'h3E},
        {6'h10, 1'b0, 2'd0, 8'h00},
        {6'h10, 1'b1, 2'd1, 8'h10},
        {6'h18, 1'b1, 2'd0, 8'hA6},
        {6'h02, 1'b1, 2'd0, 8'h86},
        {6'h20, 1'b1, 2'd0, 8'h4E},
        {6'h20, 1'b1, 2'd0, 8'h0E},
        {6'h3F, 1'b1, 2'd0, 8'h00},
        {6'h3F, 1'b1, 2'd2, 8'h00},
        {6'h00, 1'b1, 2'd0, 8'h01},
        {6'h04, 1'b0, 2'd0, 8'h00},
        {6'h04, 1'b1, 2'd0, 8'h03}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_stat = 0; m_flag = 0; m_mask = 6'h3F; m_cfg = 0;
    endtask

    task automatic model_step(input logic [5:0] c, input logic we, input logic [1:0] a, input logic [7:0] d);
        logic [5:0] keep;
        keep = (we && a == 2'd2) ? d[5:0] : 6'h3F;
        m_flag = (m_flag & keep) | (c & ~m_stat);
        m_stat = c;
        if (we && a == 2'd0) m_cfg = d;
        if (we && a == 2'd1) m_mask = d[5:0];
    endtask

    task automatic compare_all();
        logic irq, b1, b2, e1o, e1e, e2o, e2e, elo, ele;
        irq = |(m_flag & ~m_mask);
        b1  = m_stat[0] | (m_cfg[7] & m_stat[3]);
        b2  = m_stat[1] | (m_cfg[7] & m_stat[4]);
        check("R10 status", {2'b0, status_o}, {2'b0, m_stat});
        check("R2 R3 flags", {2'b0, flags_o}, {2'b0, m_flag});
        check("R4 irq", {7'b0, irq_o}, {7'b0, irq});
        if (m_cfg[0]) begin
            e1e = 1; e1o = m_cfg[4] ? irq : ~irq;
            check("R5 pin1", {6'b0, pin1_oe, pin1_o}, {6'b0, e1e, e1o});
        end else if (m_cfg[1]) begin
            e1e = 1; e1o = m_cfg[5] ? b1 : ~b1;
            check("R6 pin1", {6'b0, pin1_oe, pin1_o}, {6'b0, e1e, e1o});
        end else begin
            check("R7 pin1", {6'b0, pin1_oe, pin1_o}, 8'h00);
        end
        e2e = m_cfg[2]; e2o = m_cfg[2] & (m_cfg[5] ? b2 : ~b2);
        check("R8 pin2", {6'b0, pin2_oe, pin2_o}, {6'b0, e2e, e2o});
        ele = m_cfg[3]; elo = m_cfg[3] & (m_cfg[6] ? m_stat[5] : ~m_stat[5]);
        check("R9 lolpin", {6'b0, lolpin_oe, lolpin_o}, {6'b0, ele, elo});
    endtask

    task automatic apply(input logic [5:0] c, input logic we, input logic [1:0] a, input logic [7:0] d);
        cond_i = c; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(c, we, a, d);
        @(negedge clk);
        wr_en = 0;
        compare_all();
    endtask

    task automatic check_reset();
        check("R1 pins", {2'b0, pin1_oe, pin1_o, pin2_oe, pin2_o, lolpin_oe, lolpin_o}, 8'h00);
        check("R1 flags", {2'b0, flags_o}, 8'h00);
        check("R1 status", {2'b0, status_o}, 8'h00);
        check("R1 mask", {2'b0, mask_o}, 8'h3F);
        check("R1 cfg", cfg_o, 8'h00);
    endtask

    initial begin
        rst = 1; cond_i = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        check_reset();

        for (int i = 0; i < NV; i++)
            apply(VEC[i][16:11], VEC[i][10], VEC[i][9:8], VEC[i][7:0]);

        // R3 corner: rising condition together with its clear keeps the flag
        apply(6'h00, 1'b1, 2'd2, 8'h00);
        apply(6'h02, 1'b1, 2'd2, 8'h00);
        check("R3 rise wins over clear", {2'b0, flags_o}, 8'h02);
        // R3: writing 1 leaves the flag
        apply(6'h02, 1'b1, 2'd2, 8'h3F);
        check("R3 write one keeps", {2'b0, flags_o}, 8'h02);
        // R2: a held condition does not re-set a cleared flag
        apply(6'h02, 1'b1, 2'd2, 8'h00);
        apply(6'h02, 1'b0, 2'd0, 8'h00);
        check("R2 no re-set while held", {2'b0, flags_o}, 8'h00);

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1; cond_i = 6'h3F;
        @(negedge clk);
        rst = 0; cond_i = 0;
        check_reset();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule